// File: doc/BRIEF.md
# Frame-Aligned DDR Deserializer Receiver

This block sits behind the input buffers of an eight-channel serial converter link. Each data lane carries one bit per edge of a shared data clock, and a frame clock runs alongside them at one transition pair per sample. The receiver captures every lane, and the frame clock too, on both edges of the data clock. It shifts the bits into per-lane history registers and finds word boundaries where the captured frame pattern steps from 0 to 1. From those boundaries it rebuilds one parallel word per channel for each frame.

The word length (short or long, 10 or 12 bits by default) and the arrival order (most significant bit first, or least significant first) are chosen at run time. Either change throws away the current alignment. The output is offset binary by default, or two's complement made by inverting the top bit and sign-extending. All eight words are updated together with a one-cycle valid strobe. A lock flag reports that the frame clock has shown the expected shape for several frames in a row.

Top module: `ddr_frame_rx`

## Requirements
- R1: A lane bit sampled at a rising edge of `clk` precedes, in word order, the bit sampled at the following falling edge; bits sampled on both edges reach the words.
- R2: A word starts at the first bit whose captured `frame_in` value is 1 after a captured 0, whichever clock edge that bit was sampled on.
- R3: With `long_word` = 0 a word is WORD_SHORT bits (10), with `long_word` = 1 it is WORD_LONG bits (12); a stream of the other length never locks.
- R4: With `lsb_first` = 0 the first bit of a word is its most significant bit; with `lsb_first` = 1 the first bit is bit 0 and the output carries normal significance.
- R5: With `twos_out` = 0 the word is passed through in offset binary, zero-extended to WORD_LONG bits; with `twos_out` = 1 its top bit is inverted and copied into all higher bits of the lane field.
- R6: `locked` rises after LOCK_FRAMES (4) consecutive good frames, each of length W bits with `frame_in` 1 for the first W/2 bits and 0 for the last W/2. It rises in the same cycle as the first `word_valid` and stays high while `word_valid` pulses.
- R7: Any frame with the wrong shape or the wrong spacing, or a missing boundary, drops `locked` and restarts the count of good frames.
- R8: `word_valid` is high for exactly one cycle per good frame while locked, and all lane fields of `word_out` change in that cycle (lane n in bits n*12 .. n*12+11).
- R9: A change of `long_word` or `lsb_first` forces `locked` low on the next cycle and restarts alignment.
- R10: After reset `word_valid` and `locked` are 0 and `word_out` is all zeros.
- R11: `word_out` holds its value in every cycle without `word_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared data clock; lanes are sampled on both edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_in | input | 8 | Serial data lanes, one per channel |
| frame_in | input | 1 | Frame clock, sampled like a data lane |
| long_word | input | 1 | 0: 10-bit words, 1: 12-bit words |
| lsb_first | input | 1 | 0: most significant bit arrives first, 1: bit 0 arrives first |
| twos_out | input | 1 | 0: offset binary output, 1: two's complement output |
| word_out | output | 96 | Eight 12-bit lane fields, lane 0 in the low bits |
| word_valid | output | 1 | One-cycle strobe marking a new set of words |
| locked | output | 1 | Frame alignment established |

## Verification
The assertions check, on every cycle, that the valid strobe only appears under lock and never on two cycles in a row, that lock only rises together with a valid strobe, that the words never move without a strobe, and that any change of word length or bit order clears lock on the next cycle. Only the bench scenarios can show that the words carry the right bits in the right significance, that boundaries are found on either clock edge, and that lock needs exactly four good frames. They also show which frames are emitted or suppressed around a corrupted frame clock, and that relock happens after a mode change.

// File: rtl/ddr_rx_pkg.sv
package ddr_rx_pkg;

  typedef struct packed {
    logic long_word;
    logic lsb_first;
  } rx_cfg_t;

endpackage

// File: rtl/rx_rst_sync.sv
module rx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/ddr_pair_capture.sv
module ddr_pair_capture #(
  parameter int N = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] early,
  output logic [N-1:0] late
);

  logic [N-1:0] rise_q;
  logic [N-1:0] fall_q;

  // Rising-edge sample: the older bit of each pair.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rise_q <= '0;
    else        rise_q <= d;
  end

  // Falling-edge sample: the newer bit of each pair.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= '0;
    else        fall_q <= d;
  end

  assign early = rise_q;
  assign late  = fall_q;

endmodule

// File: rtl/frame_aligner.sv
module frame_aligner
  import ddr_rx_pkg::*;
#(
  parameter int WORD_SHORT  = 10,
  parameter int WORD_LONG   = 12,
  parameter int LOCK_FRAMES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fr_early,
  input  logic fr_late,
  input  logic long_word,
  input  logic lsb_first,
  output logic sel_odd,
  output logic emit,
  output logic locked
);

  localparam int HIST = WORD_LONG + 2;
  localparam int IDXW = $clog2(HIST);
  localparam int GAPW = $clog2(WORD_LONG) + 2;
  localparam int CNTW = $clog2(LOCK_FRAMES + 1);
  localparam logic [GAPW-1:0] HALF_S  = GAPW'(WORD_SHORT / 2);
  localparam logic [GAPW-1:0] HALF_L  = GAPW'(WORD_LONG / 2);
  localparam logic [GAPW-1:0] GAP_MAX = '1;
  localparam logic [CNTW-1:0] CNT_TOP = CNTW'(LOCK_FRAMES);

  logic [HIST-1:0] fh_q, fh_d;
  logic [GAPW-1:0] gap_q, gap_d;
  logic [CNTW-1:0] cnt_q, cnt_d, cnt_inc;
  rx_cfg_t         cfg_q, cfg_now;
  logic            lock_q, lock_d;

  logic            edge_hi, edge_lo, boundary, pat_ok, gap_hit;
  logic            frame_good, mismatch, cfg_chg;
  logic [GAPW-1:0] half_c;
  logic [IDXW-1:0] idx;
  int              w_i, half_i, s_i;

  always_comb begin
    cfg_now.long_word = long_word;
    cfg_now.lsb_first = lsb_first;
    cfg_chg = (cfg_now != cfg_q);

    w_i    = long_word ? WORD_LONG : WORD_SHORT;
    half_i = w_i / 2;
    half_c = long_word ? HALF_L : HALF_S;

    fh_d = {fh_q[HIST-3:0], fr_early, fr_late};

    // A 0 followed by a 1 marks the first bit of a new word.
    edge_hi  = !fh_q[2] && fh_q[1];
    edge_lo  = !fh_q[1] && fh_q[0];
    boundary = edge_hi || edge_lo;
    s_i      = edge_hi ? 1 : 0;

    // The finished word sits just above the new first bit:
    // its earlier half must be ones, its later half zeros.
    pat_ok = 1'b1;
    idx    = '0;
    for (int i = 0; i < WORD_LONG; i++) begin
      if (i < w_i) begin
        idx = IDXW'(s_i + 1 + i);
        if (fh_q[idx] != (i >= half_i)) pat_ok = 1'b0;
      end
    end

    gap_hit    = (gap_q == half_c);
    frame_good = boundary && pat_ok && gap_hit;
    mismatch   = boundary ? !frame_good : (gap_q >= half_c);

    if (boundary)              gap_d = GAPW'(1);
    else if (gap_q == GAP_MAX) gap_d = gap_q;
    else                       gap_d = gap_q + GAPW'(1);

    cnt_inc = (cnt_q == CNT_TOP) ? cnt_q : cnt_q + CNTW'(1);

    if (cfg_chg)         cnt_d = '0;
    else if (mismatch)   cnt_d = '0;
    else if (frame_good) cnt_d = cnt_inc;
    else                 cnt_d = cnt_q;

    lock_d = (cnt_d == CNT_TOP);
    emit   = !cfg_chg && frame_good && lock_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fh_q   <= '0;
      gap_q  <= '0;
      cnt_q  <= '0;
      cfg_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      fh_q   <= fh_d;
      gap_q  <= gap_d;
      cnt_q  <= cnt_d;
      cfg_q  <= cfg_now;
      lock_q <= lock_d;
    end
  end

  assign sel_odd = edge_hi;
  assign locked  = lock_q;

endmodule

// File: rtl/lane_word_builder.sv
module lane_word_builder #(
  parameter int WORD_SHORT = 10,
  parameter int WORD_LONG  = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_early,
  input  logic                 bit_late,
  input  logic                 long_word,
  input  logic                 lsb_first,
  input  logic                 twos_out,
  input  logic                 sel_odd,
  input  logic                 load,
  output logic [WORD_LONG-1:0] word
);

  localparam int HIST = WORD_LONG + 2;
  localparam int IDXW = $clog2(HIST);
  localparam int WIW  = $clog2(WORD_LONG);

  logic [HIST-1:0]      hist_q, hist_d;
  logic [WORD_LONG-1:0] raw, ord, fmt;
  logic [WORD_LONG-1:0] word_q;
  logic [IDXW-1:0]      hidx;
  logic [WIW-1:0]       ridx;
  logic [WIW-1:0]       top;
  logic                 sign;
  int                   w_i, s_i;

  always_comb begin
    hist_d = {hist_q[HIST-3:0], bit_early, bit_late};
    w_i    = long_word ? WORD_LONG : WORD_SHORT;
    s_i    = sel_odd ? 1 : 0;
    top    = WIW'(w_i - 1);

    // raw[w-1] is the first bit that arrived.
    raw  = '0;
    hidx = '0;
    for (int i = 0; i < WORD_LONG; i++) begin
      if (i < w_i) begin
        hidx   = IDXW'(s_i + 1 + i);
        raw[i] = hist_q[hidx];
      end
    end

    ord  = '0;
    ridx = '0;
    for (int i = 0; i < WORD_LONG; i++) begin
      if (i < w_i) begin
        ridx   = WIW'(w_i - 1 - i);
        ord[i] = lsb_first ? raw[ridx] : raw[i];
      end
    end

    sign = ~ord[top];
    fmt  = ord;
    if (twos_out) begin
      for (int i = 0; i < WORD_LONG; i++) begin
        if (i >= w_i - 1) fmt[i] = sign;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= '0;
    else if (load) word_q <= fmt;
  end

  assign word = word_q;

endmodule

// File: rtl/ddr_frame_rx.sv
module ddr_frame_rx #(
  parameter int LANES       = 8,
  parameter int WORD_SHORT  = 10,
  parameter int WORD_LONG   = 12,
  parameter int LOCK_FRAMES = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [LANES-1:0]           lane_in,
  input  logic                       frame_in,
  input  logic                       long_word,
  input  logic                       lsb_first,
  input  logic                       twos_out,
  output logic [LANES*WORD_LONG-1:0] word_out,
  output logic                       word_valid,
  output logic                       locked
);

  localparam int CAP_N = LANES + 1;

  logic             rst_i_n;
  logic [CAP_N-1:0] cap_early, cap_late;
  logic             sel_odd, emit;
  logic             valid_q;

  rx_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  ddr_pair_capture #(.N(CAP_N)) u_cap (
    .clk   (clk),
    .rst_n (rst_i_n),
    .d     ({frame_in, lane_in}),
    .early (cap_early),
    .late  (cap_late)
  );

  frame_aligner #(
    .WORD_SHORT  (WORD_SHORT),
    .WORD_LONG   (WORD_LONG),
    .LOCK_FRAMES (LOCK_FRAMES)
  ) u_align (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .fr_early  (cap_early[LANES]),
    .fr_late   (cap_late[LANES]),
    .long_word (long_word),
    .lsb_first (lsb_first),
    .sel_odd   (sel_odd),
    .emit      (emit),
    .locked    (locked)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_word_builder #(
      .WORD_SHORT (WORD_SHORT),
      .WORD_LONG  (WORD_LONG)
    ) u_lane (
      .clk       (clk),
      .rst_n     (rst_i_n),
      .bit_early (cap_early[g]),
      .bit_late  (cap_late[g]),
      .long_word (long_word),
      .lsb_first (lsb_first),
      .twos_out  (twos_out),
      .sel_odd   (sel_odd),
      .load      (emit),
      .word      (word_out[g*WORD_LONG +: WORD_LONG])
    );
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) valid_q <= 1'b0;
    else          valid_q <= emit;
  end

  assign word_valid = valid_q;

endmodule

// File: rtl/ddr_rx_checker.sv
module ddr_rx_checker #(
  parameter int WIDTH = 96
) (
  input logic             clk,
  input logic             rst_n,
  input logic             long_word,
  input logic             lsb_first,
  input logic [WIDTH-1:0] word_out,
  input logic             word_valid,
  input logic             locked
);

  p_valid_with_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> locked);

  p_lock_rise_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> word_valid);

  p_valid_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  p_cfg_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((lsb_first != $past(lsb_first)) || (long_word != $past(long_word))) |=> !locked);

  p_words_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_out) |-> word_valid);

endmodule

bind ddr_frame_rx ddr_rx_checker #(.WIDTH(LANES*WORD_LONG)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .long_word  (long_word),
  .lsb_first  (lsb_first),
  .word_out   (word_out),
  .word_valid (word_valid),
  .locked     (locked)
);

// File: tb/sim_ddr_frame_rx.sv
`timescale 1ns/1ps
module sim_ddr_frame_rx;

  localparam int LANES = 8;
  localparam int WL    = 12;

  logic             clk;
  logic             rst_n;
  logic [LANES-1:0] lane_in;
  logic             frame_in;
  logic             long_word, lsb_first, twos_out;
  logic [LANES*WL-1:0] word_out;
  logic             word_valid, locked;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Transmitter model state.
  int tx_active = 0, tx_frames = 0, tx_w = 10, tx_lsb = 0;
  int tx_f = 0, tx_p = 0, idle_left = 0, corrupt_f = -1;
  int cur_frame = 0;

  // Monitor state.
  int nvalid = 0;
  logic [63:0] vmask = '0;

  ddr_frame_rx u0 (
    .clk(clk), .rst_n(rst_n), .lane_in(lane_in), .frame_in(frame_in),
    .long_word(long_word), .lsb_first(lsb_first), .twos_out(twos_out),
    .word_out(word_out), .word_valid(word_valid), .locked(locked)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [11:0] val(int f, int l, int w);
    logic [11:0] m;
    int x;
    m = (12'(1) << w) - 12'(1);
    x = f * 53 + l * 29 + 7 + f * l * 11;
    return 12'(x) & m;
  endfunction

  function automatic logic [11:0] rev(logic [11:0] v, int w);
    logic [11:0] r = '0;
    for (int i = 0; i < w; i++) r[i] = v[w-1-i];
    return r;
  endfunction

  function automatic logic [11:0] exp_word(int f, int l);
    logic [11:0] v;
    logic s;
    v = val(f, l, tx_w);
    if ((tx_lsb != 0) != lsb_first) v = rev(v, tx_w);
    if (twos_out) begin
      s = ~v[tx_w-1];
      for (int i = tx_w - 1; i < 12; i++) v[i] = s;
    end
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, expv);
    end
  endtask

  // Drive one bit per clock edge, 5 ns after the edge.
  always @(clk) begin
    #5;
    if (idle_left > 0) begin
      frame_in = 1'b0; lane_in = '0; idle_left--;
    end else if (tx_active != 0) begin
      frame_in = (tx_p < tx_w / 2);
      if (tx_f == corrupt_f && tx_p == 2) frame_in = 1'b0;
      for (int l = 0; l < LANES; l++) begin
        logic [11:0] v;
        v = val(tx_f, l, tx_w);
        lane_in[l] = (tx_lsb != 0) ? v[tx_p] : v[tx_w-1-tx_p];
      end
      if (tx_p == 0) cur_frame = tx_f;
      tx_p++;
      if (tx_p == tx_w) begin
        tx_p = 0; tx_f++;
        if (tx_f == tx_frames) tx_active = 0;
      end
    end else begin
      frame_in = 1'b0; lane_in = '0;
    end
  end

  // Output monitor: R1/R3/R4/R5/R8 word contents on every strobe.
  always @(negedge clk) begin
    #1;
    if (rst_n && word_valid) begin
      int fe;
      bit ok;
      fe = cur_frame - 1;
      nvalid++;
      ok = (fe >= 0);
      if (ok) vmask[fe] = 1'b1;
      for (int l = 0; l < LANES; l++) begin
        logic [11:0] e;
        e = exp_word(fe, l);
        if (word_out[l*WL +: WL] !== e) begin
          ok = 0;
          $display("FAIL R1/R4/R5/R8 lane %0d frame %0d act=%0h exp=%0h",
                   l, fe, word_out[l*WL +: WL], e);
        end
      end
      checks++;
      if (!ok) fails++;
    end
  end

  task automatic start_stream(int frames, int w, int lsb, int skew, int bad);
    @(negedge clk); #2;
    nvalid = 0; vmask = '0;
    tx_w = w; tx_lsb = lsb; tx_frames = frames; corrupt_f = bad;
    tx_f = 0; tx_p = 0; cur_frame = 0;
    long_word = (w == 12); lsb_first = (lsb != 0);
    idle_left = 4 + skew;
    tx_active = 1;
  endtask

  task automatic wait_end();
    while (tx_active != 0) @(posedge clk);
    repeat (15) @(posedge clk);
  endtask

  task automatic wait_lock();
    int n = 0;
    @(negedge clk); #1;
    while (!locked && n < 300) begin @(negedge clk); #1; n++; end
  endtask

  function automatic logic [63:0] span(int a, int b);
    logic [63:0] m = '0;
    for (int i = a; i <= b; i++) m[i] = 1'b1;
    return m;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; long_word = 0; lsb_first = 0; twos_out = 0;
    lane_in = '0; frame_in = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk); #1;
    chk(word_valid == 0, "R10 valid", longint'(word_valid), 0);
    chk(locked == 0, "R10 locked", longint'(locked), 0);
    chk(word_out == '0, "R10 words", longint'(word_out[63:0]), 0);
  endtask

  // R1 R2 R6 R8: 10-bit, MSB first, offset binary.
  task automatic t_msb10(int skew, string tag);
    twos_out = 0;
    start_stream(12, 10, 0, skew, -1);
    wait_end();
    chk(vmask == span(3, 10), {tag, " R6 frames emitted"}, longint'(vmask), longint'(span(3, 10)));
    chk(nvalid == 8, {tag, " R8 strobe count"}, nvalid, 8);
    chk(locked == 0, {tag, " R7 lock lost after stream stops"}, longint'(locked), 0);
  endtask

  // R4: LSB-first arrival.
  task automatic t_lsb10();
    twos_out = 0;
    start_stream(10, 10, 1, 1, -1);
    wait_end();
    chk(vmask == span(3, 8), "R4 frames emitted", longint'(vmask), longint'(span(3, 8)));
  endtask

  // R3 R5: 12-bit words, two's complement, then offset binary.
  task automatic t_long12();
    twos_out = 1;
    start_stream(10, 12, 0, 0, -1);
    wait_end();
    chk(vmask == span(3, 8), "R3 R5 12-bit twos frames", longint'(vmask), longint'(span(3, 8)));
    twos_out = 0;
    start_stream(8, 12, 1, 1, -1);
    wait_end();
    chk(vmask == span(3, 6), "R3 12-bit offset frames", longint'(vmask), longint'(span(3, 6)));
    long_word = 0; lsb_first = 0;
  endtask

  // R7: a broken frame clock pulse in frame 6 costs frames 6..9.
  task automatic t_corrupt();
    logic [63:0] m;
    twos_out = 0;
    start_stream(16, 10, 0, 0, 6);
    wait_end();
    m = span(3, 5) | span(10, 14);
    chk(vmask == m, "R7 frames around corruption", longint'(vmask), longint'(m));
    chk(nvalid == 8, "R7 strobe count", nvalid, 8);
    corrupt_f = -1;
  endtask

  // R9: bit-order change clears lock, then relock with reversed words.
  task automatic t_cfg_order();
    int n0;
    twos_out = 0;
    start_stream(30, 10, 0, 0, -1);
    wait_lock();
    chk(locked == 1, "R6 lock reached", longint'(locked), 1);
    @(negedge clk); #2;
    lsb_first = 1;
    n0 = nvalid;
    @(posedge clk); @(negedge clk); #1;
    chk(locked == 0, "R9 order change clears lock", longint'(locked), 0);
    wait_end();
    chk(nvalid - n0 >= 5, "R9 R4 relock after order change", nvalid - n0, 5);
    lsb_first = 0;
  endtask

  // R9 R3: length change clears lock; a 10-bit stream never locks as 12-bit.
  task automatic t_cfg_len();
    int n0;
    twos_out = 0;
    start_stream(20, 10, 0, 0, -1);
    wait_lock();
    @(negedge clk); #2;
    long_word = 1;
    @(posedge clk); @(negedge clk); #1;
    chk(locked == 0, "R9 length change clears lock", longint'(locked), 0);
    n0 = nvalid;
    wait_end();
    chk(nvalid == n0, "R3 wrong length never locks", nvalid, n0);
    long_word = 0;
  endtask

  initial begin
    t_reset();
    t_msb10(0, "R1 R2 even phase");
    t_msb10(1, "R1 R2 odd phase");
    t_lsb10();
    t_long12();
    t_corrupt();
    t_cfg_order();
    t_cfg_len();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #3_000_000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule